// File: doc/BRIEF.md
# Overlapping Windowed Register File

This block is the integer register file of a core that uses rotating register windows for procedure calls. Software addresses 32 logical registers. A window pointer decides which physical registers those names reach. Eight global registers are common to every window. Each window also owns sixteen private registers: eight locals and eight ins. The eight outs of a window are not separate storage. They are the ins of the neighbouring window, so a caller can pass arguments through its outs and the callee finds them in its ins after the pointer moves.

The windows form a ring. The outs of window 0 are the ins of the highest-numbered window. The block has two combinational read ports and one synchronous write port. All three ports are translated through the same window pointer. A write that reaches the same physical register as a read in the same cycle is forwarded to that read. Logical register 0 always reads as zero.

Top module: `wrf_window_regfile`

## Requirements
- R1: After reset every logical register reads zero through both ports, in every window.
- R2: Logical r1..r7 (index bits [4:3] = 0) reach the same eight global registers whatever the window pointer holds.
- R3: Logical r16..r23 (bits [4:3] = 2) are locals private to their window. A write to them in one window is not visible in any other window.
- R4: Logical r24+k (bits [4:3] = 3) in window w is the same storage as logical r8+k (bits [4:3] = 1) in window (w+1) mod NWIN, for k in 0..7.
- R5: The ring wraps around. The outs r8..r15 of window 0 are the ins r24..r31 of window NWIN-1.
- R6: A read of index 0 returns zero. A write to index 0 changes no register.
- R7: When a read and an enabled write reach the same physical register in one cycle, the read returns the write data in that cycle.
- R8: The 5-bit pointer is used modulo NWIN. Pointer value p behaves as window p mod NWIN.
- R9: A write with wr_en_i high is stored at the rising clock edge. From the next cycle on, a read returns that data until the register is written again.
- R10: The two read ports are independent. Each returns its own register for any pair of indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all storage |
| cwp_i | input | 5 | Current window pointer, used modulo NWIN |
| rda_idx_i | input | 5 | Logical index for read port A |
| rdb_idx_i | input | 5 | Logical index for read port B |
| rda_data_o | output | DATA_W | Read port A data (combinational) |
| rdb_data_o | output | DATA_W | Read port B data (combinational) |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 5 | Logical index for the write |
| wr_data_i | input | DATA_W | Write data |

## Verification
Each register group is tried on its own. Globals are written in one window and read in another, which separates shared storage from storage that depends on the window. Locals are written and then probed from a neighbouring window to show they are private. Ins written in one window are read back as outs one window up, and outs of window 0 are read as ins of the last window, which exposes a wrong direction of overlap or a broken wrap. Same-cycle read/write pairs, pointer values above NWIN-1 and index-0 writes isolate forwarding, the modulo rule and the hardwired zero. A long run of random traffic over all pointers and indices is then compared cycle by cycle with a reference model that keeps duplicated in/out copies.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

  localparam int unsigned LIDX_W   = 5;
  localparam int unsigned GRP_SZ   = 8;
  localparam int unsigned N_GLOBAL = 8;
  localparam int unsigned WIN_SZ   = 16;

  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } reg_grp_e;

  function automatic reg_grp_e grp_of(input logic [LIDX_W-1:0] idx);
    return reg_grp_e'(idx[4:3]);
  endfunction

  function automatic int unsigned win_of(input logic [LIDX_W-1:0] ptr,
                                         input int unsigned nwin);
    return int'(ptr) % nwin;
  endfunction

  // physical layout: globals first, then per window its ins then its locals
  function automatic int unsigned phys_of(input logic [LIDX_W-1:0] idx,
                                          input int unsigned win,
                                          input int unsigned nwin);
    int unsigned slot;
    int unsigned base;
    slot = int'(idx[2:0]);
    case (grp_of(idx))
      GRP_GLOBAL: phys_of = slot;
      GRP_OUT: begin
        base    = N_GLOBAL + WIN_SZ * ((win + nwin - 1) % nwin);
        phys_of = base + slot;
      end
      GRP_LOCAL: phys_of = N_GLOBAL + WIN_SZ * win + GRP_SZ + slot;
      default:   phys_of = N_GLOBAL + WIN_SZ * win + slot;
    endcase
  endfunction

endpackage

// File: rtl/wrf_addr_map.sv
module wrf_addr_map
  import wrf_pkg::*;
#(
  parameter int unsigned NWIN   = 8,
  parameter int unsigned WIN_W  = 3,
  parameter int unsigned PIDX_W = 8
) (
  input  logic [WIN_W-1:0]  win_i,
  input  logic [LIDX_W-1:0] idx_i,
  output logic [PIDX_W-1:0] phys_o,
  output logic              is_zero_o
);

  always_comb begin
    phys_o    = PIDX_W'(phys_of(idx_i, int'(win_i), NWIN));
    is_zero_o = (idx_i == '0);
  end

endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PHYS   = 136,
  parameter int unsigned PIDX_W = 8,
  parameter int unsigned NRD    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_commit_i,
  input  logic [PIDX_W-1:0] wr_phys_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PIDX_W-1:0] rd_phys_i [NRD],
  output logic [DATA_W-1:0] rd_data_o [NRD]
);

  logic [DATA_W-1:0] mem_q [PHYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(PHYS); i++) mem_q[i] <= '0;
    end else if (wr_commit_i) begin
      mem_q[wr_phys_i] <= wr_data_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data_o[g] = mem_q[rd_phys_i[g]];
  end

endmodule

// File: rtl/wrf_read_port.sv
module wrf_read_port #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PIDX_W = 8
) (
  input  logic              is_zero_i,
  input  logic [PIDX_W-1:0] rd_phys_i,
  input  logic [DATA_W-1:0] stored_i,
  input  logic              wr_commit_i,
  input  logic [PIDX_W-1:0] wr_phys_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              fwd_o,
  output logic [DATA_W-1:0] data_o
);

  always_comb begin
    fwd_o = wr_commit_i && (wr_phys_i == rd_phys_i);
    if (is_zero_i)  data_o = '0;
    else if (fwd_o) data_o = wr_data_i;
    else            data_o = stored_i;
  end

endmodule

// File: rtl/wrf_window_regfile.sv
module wrf_window_regfile
  import wrf_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NWIN   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        cwp_i,
  input  logic [4:0]        rda_idx_i,
  input  logic [4:0]        rdb_idx_i,
  output logic [DATA_W-1:0] rda_data_o,
  output logic [DATA_W-1:0] rdb_data_o,
  input  logic              wr_en_i,
  input  logic [4:0]        wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i
);

  localparam int unsigned PHYS   = N_GLOBAL + WIN_SZ * NWIN;
  localparam int unsigned PIDX_W = $clog2(PHYS);
  localparam int unsigned WIN_W  = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam int unsigned NRD    = 2;

  logic [WIN_W-1:0]  cur_win;
  logic [LIDX_W-1:0] rd_idx   [NRD];
  logic [PIDX_W-1:0] rd_phys  [NRD];
  logic [DATA_W-1:0] rd_store [NRD];
  logic [DATA_W-1:0] rd_data  [NRD];
  logic              rd_zero  [NRD];
  logic              rd_fwd   [NRD];

  logic [PIDX_W-1:0] wr_phys;
  logic              wr_zero;
  logic              wr_commit;

  // named events for the checker
  logic [PIDX_W-1:0] ra_phys_w;
  logic [PIDX_W-1:0] rb_phys_w;

  assign cur_win   = WIN_W'(win_of(cwp_i, NWIN));
  assign rd_idx[0] = rda_idx_i;
  assign rd_idx[1] = rdb_idx_i;

  wrf_addr_map #(.NWIN(NWIN), .WIN_W(WIN_W), .PIDX_W(PIDX_W)) u_wr_map (
    .win_i    (cur_win),
    .idx_i    (wr_idx_i),
    .phys_o   (wr_phys),
    .is_zero_o(wr_zero)
  );

  assign wr_commit = wr_en_i && !wr_zero;

  for (genvar g = 0; g < NRD; g++) begin : g_port
    wrf_addr_map #(.NWIN(NWIN), .WIN_W(WIN_W), .PIDX_W(PIDX_W)) u_map (
      .win_i    (cur_win),
      .idx_i    (rd_idx[g]),
      .phys_o   (rd_phys[g]),
      .is_zero_o(rd_zero[g])
    );
    wrf_read_port #(.DATA_W(DATA_W), .PIDX_W(PIDX_W)) u_rp (
      .is_zero_i  (rd_zero[g]),
      .rd_phys_i  (rd_phys[g]),
      .stored_i   (rd_store[g]),
      .wr_commit_i(wr_commit),
      .wr_phys_i  (wr_phys),
      .wr_data_i  (wr_data_i),
      .fwd_o      (rd_fwd[g]),
      .data_o     (rd_data[g])
    );
  end

  wrf_storage #(.DATA_W(DATA_W), .PHYS(PHYS), .PIDX_W(PIDX_W), .NRD(NRD)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_commit_i(wr_commit),
    .wr_phys_i  (wr_phys),
    .wr_data_i  (wr_data_i),
    .rd_phys_i  (rd_phys),
    .rd_data_o  (rd_store)
  );

  assign ra_phys_w  = rd_phys[0];
  assign rb_phys_w  = rd_phys[1];
  assign rda_data_o = rd_data[0];
  assign rdb_data_o = rd_data[1];

endmodule

// File: rtl/wrf_window_regfile_chk.sv
module wrf_window_regfile_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PHYS   = 136,
  parameter int unsigned PIDX_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        ra_idx,
  input logic [4:0]        rb_idx,
  input logic [DATA_W-1:0] ra_data,
  input logic [DATA_W-1:0] rb_data,
  input logic              wr_commit,
  input logic [PIDX_W-1:0] wr_phys,
  input logic [DATA_W-1:0] wr_data,
  input logic [PIDX_W-1:0] ra_phys,
  input logic [PIDX_W-1:0] rb_phys
);

  // R6
  r0_port_a_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_idx == 5'd0) |-> (ra_data == '0));

  // R6
  r0_port_b_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_idx == 5'd0) |-> (rb_data == '0));

  // R7
  fwd_port_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && ra_phys == wr_phys && ra_idx != 5'd0) |-> (ra_data == wr_data));

  // R7
  fwd_port_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && rb_phys == wr_phys && rb_idx != 5'd0) |-> (rb_data == wr_data));

  // R9
  write_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_commit) && !wr_commit && ra_idx != 5'd0 &&
     ra_phys == $past(wr_phys)) |-> (ra_data == $past(wr_data)));

  // R8
  phys_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ra_phys) < int'(PHYS)) && (int'(rb_phys) < int'(PHYS)));

endmodule

bind wrf_window_regfile wrf_window_regfile_chk #(
  .DATA_W(DATA_W), .PHYS(PHYS), .PIDX_W(PIDX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ra_idx   (rda_idx_i),
  .rb_idx   (rdb_idx_i),
  .ra_data  (rda_data_o),
  .rb_data  (rdb_data_o),
  .wr_commit(wr_commit),
  .wr_phys  (wr_phys),
  .wr_data  (wr_data_i),
  .ra_phys  (ra_phys_w),
  .rb_phys  (rb_phys_w)
);

// File: tb/wrf_window_regfile_tb.sv
module wrf_window_regfile_tb_top;

  localparam int CLK_P = 10;
  localparam int NW    = 8;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    cwp_i = '0;
  logic [4:0]    rda_idx_i = '0;
  logic [4:0]    rdb_idx_i = '0;
  logic [DW-1:0] rda_data_o;
  logic [DW-1:0] rdb_data_o;
  logic          wr_en_i = 1'b0;
  logic [4:0]    wr_idx_i = '0;
  logic [DW-1:0] wr_data_i = '0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  wrf_window_regfile #(.DATA_W(DW), .NWIN(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cwp_i(cwp_i),
    .rda_idx_i(rda_idx_i), .rdb_idx_i(rdb_idx_i),
    .rda_data_o(rda_data_o), .rdb_data_o(rdb_data_o),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i)
  );

  // reference model: every window keeps its own outs copy, kept coherent
  logic [DW-1:0] m_glob [8];
  logic [DW-1:0] m_in   [NW][8];
  logic [DW-1:0] m_loc  [NW][8];
  logic [DW-1:0] m_out  [NW][8];

  task automatic m_clear();
    for (int k = 0; k < 8; k++) begin
      m_glob[k] = '0;
      for (int w = 0; w < NW; w++) begin
        m_in[w][k] = '0; m_loc[w][k] = '0; m_out[w][k] = '0;
      end
    end
  endtask

  function automatic logic [DW-1:0] m_read(int w, int idx);
    int k = idx % 8;
    if (idx == 0) return '0;
    if (idx < 8)  return m_glob[k];
    if (idx < 16) return m_out[w][k];
    if (idx < 24) return m_loc[w][k];
    return m_in[w][k];
  endfunction

  task automatic m_write(int w, int idx, logic [DW-1:0] d);
    int k = idx % 8;
    if (idx == 0) return;
    if (idx < 8) m_glob[k] = d;
    else if (idx < 16) begin
      m_out[w][k] = d;
      m_in[(w + NW - 1) % NW][k] = d;
    end else if (idx < 24) m_loc[w][k] = d;
    else begin
      m_in[w][k] = d;
      m_out[(w + 1) % NW][k] = d;
    end
  endtask

  task automatic check(string tag, string port, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s port %s: got %h expected %h", tag, port, got, exp);
    end
  endtask

  // one clock cycle: drive, update model with the write, compare both reads
  task automatic step(bit we, int widx, logic [DW-1:0] wd, int cw, int ia, int ib, string tag);
    int w;
    @(negedge clk);
    wr_en_i = we; wr_idx_i = 5'(widx); wr_data_i = wd;
    cwp_i = 5'(cw); rda_idx_i = 5'(ia); rdb_idx_i = 5'(ib);
    #(CLK_P/4);
    w = cw % NW;
    if (we) m_write(w, widx, wd);
    check(tag, "A", rda_data_o, m_read(w, ia));
    check(tag, "B", rdb_data_o, m_read(w, ib));
  endtask

  task automatic rd(int cw, int ia, int ib, string tag);
    step(1'b0, 0, '0, cw, ia, ib, tag);
  endtask

  task automatic wr(int cw, int idx, logic [DW-1:0] d, string tag);
    step(1'b1, idx, d, cw, idx, 0, tag);
  endtask

  initial begin
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: everything zero after reset
    for (int w = 0; w < NW; w++)
      for (int i = 0; i < 32; i += 2) rd(w, i, i + 1, "R1");

    // R2: globals shared across windows
    for (int i = 1; i < 8; i++) wr(0, i, 32'h1000_0000 + i, "R2");
    for (int i = 1; i < 8; i++) rd(5, i, 8 - i, "R2");

    // R3: locals private
    for (int i = 16; i < 24; i++) wr(2, i, 32'h2200_0000 + i, "R3");
    for (int i = 16; i < 24; i++) rd(3, i, i, "R3");
    for (int i = 16; i < 24; i++) rd(2, i, 39 - i, "R3");

    // R4: ins of w are outs of w+1, both directions
    for (int k = 0; k < 8; k++) wr(3, 24 + k, 32'h3400_0000 + k, "R4");
    for (int k = 0; k < 8; k++) rd(4, 8 + k, 24 + k, "R4");
    wr(6, 10, 32'h6600_000a, "R4");
    rd(5, 26, 10, "R4");

    // R5: ring wrap between window 0 and the last window
    for (int k = 0; k < 8; k++) wr(0, 8 + k, 32'h5000_0000 + k, "R5");
    for (int k = 0; k < 8; k++) rd(NW - 1, 24 + k, 8 + k, "R5");
    wr(NW - 1, 31, 32'h5777_0031, "R5");
    rd(0, 15, 31, "R5");

    // R6: index 0 hardwired, writes to it discarded
    step(1'b1, 0, 32'hffff_ffff, 1, 0, 0, "R6");
    rd(1, 0, 0, "R6");
    for (int i = 1; i < 32; i++) rd(1, i, 0, "R6");

    // R7: same-cycle forwarding on both ports
    step(1'b1, 20, 32'h7070_2020, 1, 20, 20, "R7");
    step(1'b1, 12, 32'h7070_1212, 4, 12, 3, "R7");
    step(1'b1, 5, 32'h7070_0505, 6, 1, 5, "R7");

    // R9: value held in later cycles
    wr(1, 18, 32'h9999_0018, "R9");
    rd(1, 18, 18, "R9");
    rd(1, 17, 18, "R9");

    // R8: pointer modulo NWIN
    step(1'b1, 17, 32'h8888_0011, 11, 17, 0, "R8");
    rd(3, 17, 17, "R8");
    step(1'b1, 25, 32'h8888_0019, 31, 0, 25, "R8");
    rd(7, 25, 25, "R8");
    rd(16, 9, 9, "R8");

    // R10: random traffic over all pointers and indices
    for (int n = 0; n < 3000; n++)
      step(1'($urandom % 4 != 0), int'($urandom % 32), $urandom,
           int'($urandom % 32), int'($urandom % 32), int'($urandom % 32), "R10");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule